// File: doc/BRIEF.md
# MDIO Management Master

This block is a serial management master for Ethernet PHYs. It drives the management clock (MDC) and the bidirectional management data line (MDIO). Software reaches it through four 32-bit registers selected by a 2-bit index: configuration (0), address (1), data (2) and operation (3). Writing the operation register launches one management frame. The frame is built from the latched configuration, address and data values. MDC runs only while the frame is in flight.

The same shift engine carries both frame families. A start code of 01 gives direct register access with write and read. A start code of 00 gives indirect access, where the opcode chooses address, write, read-with-increment or read. The leading 32-bit preamble can be switched off. The sampled input can be inverted or forced to zero. On read frames the register address can optionally step by one when the frame ends.

The MDIO pad is modelled as three plain signals: an output value, an output enable and an input.

Top module: `mdio_master`

## Requirements
- R1: After synchronous reset, all four registers read 0, MDC is low and the MDIO output enable is low.
- R2: Writing the operation register while idle starts a frame, and the busy flag rises on the next clock. A write to the operation register while busy is ignored: neither its opcode nor its stored value takes effect, and no second frame follows.
- R3: MDC is low whenever no frame is in flight. Each MDC half period lasts max(D,1)+1 system clocks, where D is configuration bits [12:5], latched at frame start.
- R4: A frame is sent MSB first in this order: 32 ones when configuration bit 2 is set (none when it is clear), the start code from configuration bits [4:3], the opcode from operation bits [1:0], the PHY address from address bits [9:5], the register address from address bits [4:0], 2 turnaround bits and 16 data bits.
- R5: When opcode bit 1 is 0 (direct write, indirect address, indirect write), the whole frame is driven. The turnaround is 1 then 0, and the data field is data register bits [15:0].
- R6: When opcode bit 1 is 1 (any read), the output enable is low for the last 18 bits, and the data register receives the 16 sampled bits when the frame ends.
- R7: MDIO is sampled on each MDC rising edge as (mdio_i XOR configuration bit 1) when configuration bit 0 is set, and as 0 when it is clear.
- R8: When operation bit 2 was set in the starting write and the frame is a read, address bits [4:0] increase by one modulo 32 at frame end. Write-type frames leave the address unchanged.
- R9: The operation register reads back with bit 31 as the busy flag and bits [2:0] as the value written by the last accepted start.
- R10: The MDIO output value changes only when MDC falls or when a frame starts; it holds steady while MDC is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 2 | Register index: 0 config, 1 address, 2 data, 3 operation |
| bus_we | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the register selected on the previous clock |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable, high to drive |
| mdio_i | input | 1 | MDIO input value |

## Verification
The bench targets wrap-around of the register address from 31 to 0 on an auto-incrementing read. A design with a wrong field width would carry into the PHY address. It checks that a write frame with auto-increment set leaves the address alone, and that an operation write during a frame leaves no mark: a design that re-armed would launch a second frame or flip the first into a read. It measures the first MDC low phase at divider values 0 through 3, because mishandling a divider of 0 gives a one-clock half period. It checks that inversion and the input-disable bit reach the captured data, and that dropping the preamble shifts the frame so that it starts at the start code.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_DATA = 2'd2,
    SEL_OP   = 2'd3
  } reg_sel_e;

  localparam int CFG_IN_EN = 0;
  localparam int CFG_INV   = 1;
  localparam int CFG_PRE   = 2;
  localparam int CFG_SOF   = 3;
  localparam int CFG_DIV   = 5;
  localparam int OP_AINC   = 2;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  assign lim  = (div == '0) ? DIV_W'(1) : div;
  assign tick = run && (cnt_q == lim);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R3
  half_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q <= lim));
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq #(
  parameter int PRE_W  = 32,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              pre_en,
  input  logic [1:0]        sof,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] phy,
  input  logic [ADDR_W-1:0] rga,
  input  logic [DATA_W-1:0] wdat,
  input  logic              tick,
  input  logic              in_en,
  input  logic              in_inv,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic [DATA_W-1:0] cap
);
  localparam int CORE_W = 6 + 2 * ADDR_W + DATA_W;
  localparam int TOT_W  = PRE_W + CORE_W;
  localparam int CNT_W  = $clog2(TOT_W + 1);

  logic              is_rd;
  logic [CORE_W-1:0] core_v, core_m;
  logic [TOT_W-1:0]  load_v, load_m;
  logic [TOT_W-1:0]  sh_q, msk_q;
  logic [CNT_W-1:0]  left_q;
  logic              sample;

  always_comb begin
    is_rd  = op[1];
    core_v = {sof, op, phy, rga, (is_rd ? 2'b00 : 2'b10), (is_rd ? {DATA_W{1'b0}} : wdat)};
    if (is_rd) core_m = {{(CORE_W-DATA_W-2){1'b1}}, {(DATA_W+2){1'b0}}};
    else       core_m = '1;
    if (pre_en) begin
      load_v = {{PRE_W{1'b1}}, core_v};
      load_m = {{PRE_W{1'b1}}, core_m};
    end else begin
      load_v = {core_v, {PRE_W{1'b0}}};
      load_m = {core_m, {PRE_W{1'b1}}};
    end
    sample = in_en & (mdio_i ^ in_inv);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      mdc     <= 1'b0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
      done    <= 1'b0;
      cap     <= '0;
      sh_q    <= '0;
      msk_q   <= '0;
      left_q  <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy    <= 1'b1;
        mdc     <= 1'b0;
        sh_q    <= load_v;
        msk_q   <= load_m;
        mdio_o  <= load_v[TOT_W-1];
        mdio_oe <= 1'b1;
        left_q  <= pre_en ? CNT_W'(TOT_W) : CNT_W'(CORE_W);
      end else if (busy && tick) begin
        if (!mdc) begin
          mdc <= 1'b1;
          if (left_q <= CNT_W'(DATA_W)) cap <= {cap[DATA_W-2:0], sample};
        end else begin
          mdc   <= 1'b0;
          sh_q  <= sh_q << 1;
          msk_q <= msk_q << 1;
          if (left_q == CNT_W'(1)) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
          end else begin
            left_q  <= left_q - 1'b1;
            mdio_o  <= sh_q[TOT_W-2];
            mdio_oe <= msk_q[TOT_W-2];
          end
        end
      end
    end
  end

  // R10
  drive_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mdc |=> (!mdc || $stable(mdio_o)));
  // R6
  oe_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> busy);
  // R3
  idle_mdc_low_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);
  // R2
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int DIV_W  = 8,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int PRE_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       bus_sel,
  input  logic             bus_we,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  localparam int CFG_W = CFG_DIV + DIV_W;
  localparam int AR_W  = 2 * ADDR_W;

  logic [CFG_W-1:0]  cfg_q;
  logic [AR_W-1:0]   addr_q;
  logic [DATA_W-1:0] data_q;
  logic [2:0]        op_q;
  logic [DIV_W-1:0]  div_q;
  logic              busy, done, tick, start;
  logic [DATA_W-1:0] cap;
  logic              unused_wbits;

  assign unused_wbits = ^bus_wdata[BUS_W-1:CFG_W];
  assign start = bus_we && (bus_sel == SEL_OP) && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      op_q   <= '0;
      div_q  <= '0;
    end else begin
      if (bus_we && bus_sel == SEL_CFG)  cfg_q  <= bus_wdata[CFG_W-1:0];
      if (bus_we && bus_sel == SEL_ADDR) addr_q <= bus_wdata[AR_W-1:0];
      if (bus_we && bus_sel == SEL_DATA) data_q <= bus_wdata[DATA_W-1:0];
      if (start) begin
        op_q  <= bus_wdata[2:0];
        div_q <= cfg_q[CFG_W-1:CFG_DIV];
      end
      if (done && op_q[1]) begin
        data_q <= cap;
        if (op_q[OP_AINC]) addr_q[ADDR_W-1:0] <= addr_q[ADDR_W-1:0] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (bus_sel)
        SEL_CFG:  bus_rdata <= BUS_W'(cfg_q);
        SEL_ADDR: bus_rdata <= BUS_W'(addr_q);
        SEL_DATA: bus_rdata <= BUS_W'(data_q);
        default:  bus_rdata <= {busy, {(BUS_W-4){1'b0}}, op_q};
      endcase
    end
  end

  mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk  (clk),
    .rst  (rst),
    .run  (busy),
    .div  (div_q),
    .tick (tick)
  );

  mdio_seq #(.PRE_W(PRE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .pre_en  (cfg_q[CFG_PRE]),
    .sof     (cfg_q[CFG_SOF+1:CFG_SOF]),
    .op      (bus_wdata[1:0]),
    .phy     (addr_q[AR_W-1:ADDR_W]),
    .rga     (addr_q[ADDR_W-1:0]),
    .wdat    (data_q),
    .tick    (tick),
    .in_en   (cfg_q[CFG_IN_EN]),
    .in_inv  (cfg_q[CFG_INV]),
    .mdio_i  (mdio_i),
    .busy    (busy),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .done    (done),
    .cap     (cap)
  );

  // R2
  start_from_op_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(bus_we && bus_sel == SEL_OP));
  // R9
  op_stable_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(op_q));
endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_sel = 2'd0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b0;
  int nvec = 0;
  int nmis = 0;

  always #5 clk = ~clk;

  mdio_master u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // fields: pre sof op ai phy rg data en inv rsp div exp_data
  localparam int NV = 6;
  localparam logic [73:0] VT [NV] = '{
    {1'b1, 2'b01, 2'b01, 1'b1, 5'h05, 5'h0A, 16'hBEEF, 1'b1, 1'b0, 16'h0000, 8'd0, 16'hBEEF},
    {1'b1, 2'b01, 2'b10, 1'b0, 5'h1F, 5'h01, 16'h1234, 1'b1, 1'b0, 16'hA5C3, 8'd1, 16'hA5C3},
    {1'b0, 2'b00, 2'b00, 1'b0, 5'h03, 5'h07, 16'h0F0F, 1'b1, 1'b0, 16'h0000, 8'd0, 16'h0F0F},
    {1'b0, 2'b00, 2'b11, 1'b1, 5'h11, 5'h1E, 16'h0000, 1'b1, 1'b1, 16'h00FF, 8'd2, 16'hFF00},
    {1'b0, 2'b00, 2'b10, 1'b1, 5'h00, 5'h1F, 16'h0000, 1'b0, 1'b0, 16'hFFFF, 8'd0, 16'h0000},
    {1'b1, 2'b01, 2'b01, 1'b0, 5'h10, 5'h10, 16'h8001, 1'b1, 1'b0, 16'h0000, 8'd3, 16'h8001}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nmis++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] v);
    @(negedge clk);
    bus_sel = s; bus_wdata = v; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk);
    bus_sel = s; bus_we = 1'b0;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic run_frame(input logic [2:0] opw, input int total, input logic [15:0] rsp,
                           input bit inject, output logic [63:0] bits, output int rel,
                           output int halfm);
    int k; bit pm; bit injd; int guard; int idx;
    bits = '0; rel = 0; halfm = 0; k = 0; pm = 1'b0; injd = 1'b0; guard = 0;
    @(negedge clk);
    bus_sel = 2'd3; bus_wdata = {29'd0, opw}; bus_we = 1'b1; mdio_i = 1'b0;
    @(negedge clk);
    bus_we = 1'b0;
    while (!(k == total && !mdc) && guard < 20000) begin
      guard++;
      if (mdc && !pm) begin
        bits[63-k] = mdio_o;
        if (!mdio_oe) rel++;
        k++;
      end else if (!mdc && pm) begin
        idx = k - (total - 16);
        mdio_i = (idx >= 0 && idx < 16) ? rsp[15-idx] : 1'b0;
      end
      if (k == 0 && !mdc) halfm++;
      pm = mdc;
      if (inject && k == 3 && !injd) begin
        bus_we = 1'b1; bus_wdata = 32'd6; injd = 1'b1;
      end else bus_we = 1'b0;
      @(negedge clk);
    end
    bus_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nmis++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [63:0] bits, full, msk;
    logic [31:0] core;
    int rel, halfm, total, hexp, hi;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 mdc", {63'd0, mdc}, 64'd0);
    chk("R1 oe", {63'd0, mdio_oe}, 64'd0);
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), v);
      chk("R1 reg", {32'd0, v}, 64'd0);
    end

    for (int i = 0; i < NV; i++) begin
      logic pre, ai, en, inv, isrd;
      logic [1:0] sof, op;
      logic [4:0] phy, rg;
      logic [15:0] dat, rsp, expd;
      logic [7:0] dv;
      pre = VT[i][73]; sof = VT[i][72:71]; op = VT[i][70:69]; ai = VT[i][68];
      phy = VT[i][67:63]; rg = VT[i][62:58]; dat = VT[i][57:42];
      en = VT[i][41]; inv = VT[i][40]; rsp = VT[i][39:24]; dv = VT[i][23:16];
      expd = VT[i][15:0];
      isrd = op[1];
      wr(2'd0, {19'd0, dv, sof, pre, inv, en});
      wr(2'd1, {22'd0, phy, rg});
      wr(2'd2, {16'd0, dat});
      total = pre ? 64 : 32;
      run_frame({ai, op}, total, rsp, 1'b0, bits, rel, halfm);
      core = {sof, op, phy, rg, (isrd ? 2'b00 : 2'b10), (isrd ? 16'h0 : dat)};
      full = pre ? {32'hFFFFFFFF, core} : {core, 32'h0};
      if (isrd) msk = pre ? {{46{1'b1}}, 18'd0} : {{14{1'b1}}, 50'd0};
      else      msk = pre ? {64{1'b1}} : {{32{1'b1}}, 32'd0};
      // R4 R5 frame content
      chk("R4/R5 frame bits", bits & msk, full & msk);
      // R6 release window
      chk("R6 released bits", 64'(rel), isrd ? 64'd18 : 64'd0);
      // R3 half period
      hexp = ((dv == 0) ? 1 : int'(dv)) + 1;
      chk("R3 half period", 64'(halfm), 64'(hexp));
      // R6 R7 captured data
      rd(2'd2, v);
      chk("R6/R7 data reg", {32'd0, v}, {48'd0, expd});
      // R8 address step
      rd(2'd1, v);
      chk("R8 address reg", {32'd0, v}, {54'd0, phy, rg + 5'((ai && isrd) ? 1 : 0)});
      // R9 op readback, busy clear
      rd(2'd3, v);
      chk("R9 op reg", {32'd0, v}, {61'd0, ai, op});
    end

    // R2 op write while busy is ignored
    wr(2'd0, {19'd0, 8'd0, 2'b01, 1'b0, 1'b0, 1'b1});
    wr(2'd2, 32'h00001111);
    run_frame(3'b001, 32, 16'h0, 1'b1, bits, rel, halfm);
    chk("R2 frame stays write", 64'(rel), 64'd0);
    rd(2'd2, v);
    chk("R2 data unchanged", {32'd0, v}, 64'h1111);
    rd(2'd3, v);
    chk("R2 op value kept", {32'd0, v}, 64'd1);
    hi = 0;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (mdc) hi++;
    end
    chk("R2/R3 no second frame", 64'(hi), 64'd0);

    // R9 busy flag visible mid frame
    wr(2'd3, 32'd1);
    rd(2'd3, v);
    chk("R9 busy set", {63'd0, v[31]}, 64'd1);
    repeat (200) @(negedge clk);
    rd(2'd3, v);
    chk("R9 busy cleared", {63'd0, v[31]}, 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end
endmodule